// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block brings switchable logic domains up and down in a fixed safe order. For each domain it drives a clock enable, a reset, a set of staged power-switch enables and an isolation control. It also holds a gate wait word for each domain. A request names one domain and a direction. The sequencer then writes one control value per stage. After each write it waits a settle interval, which is given with the request and counted in clock cycles.

Power-up closes the switches one at a time in a cumulative thermometer order, which limits inrush current. Reset is released only after every switch is closed. Isolation is dropped last. Power-down runs the reverse order. Only one domain is sequenced at a time. A request that arrives while a sequence runs is dropped, and a sticky error flag records it. Each domain's three control words and a status word can be read through a small read port.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, every domain has its clock off with reset held (control word 1), all switches open with isolation active (switch word 0), and gate word 0. `busy`, `done` and the status word are all 0.
- R2: A power-up request writes nine stages in this order: control 3, gate word 0x1FFFFFE, switch word 0x01, 0x03, 0x07, 0x0F, gate word 0x1FFFFFF, control 2, switch word 0x1F.
- R3: A power-down request writes five stages in this order: switch word 0x0F, gate word 0, control 3, control 1, switch word 0.
- R4: With settle value S captured at acceptance, stage k (counting from 0) is written at the clock edge (k+1)*(S+1) edges after the accepting edge.
- R5: `busy` rises at the accepting edge and falls at the edge that writes the last stage. `done` is high for exactly the cycle that follows that edge.
- R6: A request to power up a domain that is already on, or to power down a domain that is already off, raises `done` in the next cycle. It leaves `busy` low and leaves every register and output unchanged.
- R7: A request made while `busy` is high is dropped, with no effect on any domain, and sets the sticky error bit (status bit 31).
- R8: A request naming a domain index of NUM_DOM or more is dropped and sets the sticky error bit.
- R9: The read view is as follows. Domain d occupies byte address 12*d: gate word at +0, control at +4 (bit 1 clock enable, bit 0 reset), switch word at +8 (bits 3:0 switches, bit 4 isolation release). The status word is at 12*NUM_DOM, with bit d set while domain d is on and bit 31 the error flag. Any other address reads 0.
- R10: The switch bits of a domain always form a thermometer code. Reset is released only while all switches are closed. Isolation is released only while the clock runs and reset is released.
- R11: At most one domain's outputs change in any cycle, and a sequence never alters another domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_up | input | 1 | 1 = power up, 0 = power down |
| req_dom | input | DOM_W | Target domain index |
| settle_len | input | SETTLE_W | Extra wait cycles after each stage |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | ADDR_W | Byte address of the read view |
| rd_data | output | 32 | Read data, combinational |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_rst | output | NUM_DOM | Per-domain reset, active high |
| dom_sw | output | NUM_DOM*SW_N | Per-domain power-switch enables |
| dom_iso | output | NUM_DOM | Per-domain isolation, 1 = isolated |

## Verification
The bench counts edges from the edge that accepts a request. `busy` is due one edge later. Stage k lands (k+1)*(S+1) edges after acceptance. `done` and the fall of `busy` come with the last stage. An ignored request or a dropped request shows its `done` pulse or its error bit one edge later. Every value is sampled on the falling edge that follows the edge where it is due. The read port is combinational, so the three words of a domain are read within that same low phase. The expected value of every stage is checked on every cycle of every sequence, for three settle values and every domain.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
   typedef enum logic [1:0] {
      SEL_GATE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_SW   = 2'd2
   } reg_sel_t;

   localparam int unsigned DOM_STRIDE = 12;
   localparam logic [1:0]  CTRL_OFF_RST = 2'b01;
   localparam logic [1:0]  CTRL_ON_RST  = 2'b11;
   localparam logic [1:0]  CTRL_ON_RUN  = 2'b10;
endpackage

// File: rtl/pgs_step_table.sv
`timescale 1ns/1ps
// Value and target register of each sequencing stage.
module pgs_step_table
   import pgs_pkg::*;
#(
   parameter int SW_N   = 4,
   parameter int GATE_W = 25,
   parameter int STEP_W = 4
)(
   input  logic              up,
   input  logic [STEP_W-1:0] idx,
   output reg_sel_t          sel,
   output logic [GATE_W-1:0] val,
   output logic              last
);
   localparam logic [GATE_W-1:0] GATE_SETUP = {{(GATE_W-1){1'b1}}, 1'b0};
   localparam logic [GATE_W-1:0] ONE        = GATE_W'(1);

   always_comb begin
      sel = SEL_SW;
      val = '0;
      if (up) begin
         if (idx == STEP_W'(0)) begin
            sel = SEL_CTRL;
            val = GATE_W'(CTRL_ON_RST);
         end else if (idx == STEP_W'(1)) begin
            sel = SEL_GATE;
            val = GATE_SETUP;
         end else if (idx <= STEP_W'(SW_N + 1)) begin
            // one more switch per stage, lower ones stay closed
            sel = SEL_SW;
            val = (ONE << (idx - STEP_W'(1))) - ONE;
         end else if (idx == STEP_W'(SW_N + 2)) begin
            sel = SEL_GATE;
            val = GATE_SETUP | ONE;
         end else if (idx == STEP_W'(SW_N + 3)) begin
            sel = SEL_CTRL;
            val = GATE_W'(CTRL_ON_RUN);
         end else begin
            sel = SEL_SW;
            val = (ONE << (SW_N + 1)) - ONE;
         end
      end else begin
         if (idx == STEP_W'(0)) begin
            sel = SEL_SW;
            val = (ONE << SW_N) - ONE;
         end else if (idx == STEP_W'(1)) begin
            sel = SEL_GATE;
            val = '0;
         end else if (idx == STEP_W'(2)) begin
            sel = SEL_CTRL;
            val = GATE_W'(CTRL_ON_RST);
         end else if (idx == STEP_W'(3)) begin
            sel = SEL_CTRL;
            val = GATE_W'(CTRL_OFF_RST);
         end else begin
            sel = SEL_SW;
            val = '0;
         end
      end
   end

   assign last = up ? (idx == STEP_W'(SW_N + 4)) : (idx == STEP_W'(4));
endmodule

// File: rtl/pgs_settle_timer.sv
`timescale 1ns/1ps
// Counts the settle interval of the current stage.
module pgs_settle_timer #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         run,
   input  logic [W-1:0] len,
   output logic         at_end
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (run)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_end = run && (cnt_q == len);
endmodule

// File: rtl/pgs_domain.sv
`timescale 1ns/1ps
// Control words of one switchable domain.
module pgs_domain
   import pgs_pkg::*;
#(
   parameter int SW_N   = 4,
   parameter int GATE_W = 25
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_t          sel,
   input  logic [GATE_W-1:0] val,
   input  logic              fin,
   input  logic              fin_up,
   output logic [GATE_W-1:0] gate_q,
   output logic [1:0]        ctrl_q,
   output logic [SW_N:0]     sw_q,
   output logic              on_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
         ctrl_q <= CTRL_OFF_RST;
         sw_q   <= '0;
         on_q   <= 1'b0;
      end else begin
         if (wr_en) begin
            case (sel)
               SEL_GATE: gate_q <= val;
               SEL_CTRL: ctrl_q <= val[1:0];
               default:  sw_q   <= val[SW_N:0];
            endcase
         end
         if (fin) on_q <= fin_up;
      end
   end
endmodule

// File: rtl/pwr_gate_seq.sv
`timescale 1ns/1ps
module pwr_gate_seq
   import pgs_pkg::*;
#(
   parameter int NUM_DOM  = 3,
   parameter int SW_N     = 4,
   parameter int GATE_W   = 25,
   parameter int SETTLE_W = 8,
   parameter int ADDR_W   = 8,
   parameter int DOM_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_up,
   input  logic [DOM_W-1:0]         req_dom,
   input  logic [SETTLE_W-1:0]      settle_len,
   output logic                     busy,
   output logic                     done,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [31:0]              rd_data,
   output logic [NUM_DOM-1:0]       dom_clk_en,
   output logic [NUM_DOM-1:0]       dom_rst,
   output logic [NUM_DOM*SW_N-1:0]  dom_sw,
   output logic [NUM_DOM-1:0]       dom_iso
);
   localparam int STEP_W      = $clog2(SW_N + 5);
   localparam int DOM_SLOTS   = 1 << DOM_W;
   localparam int STATUS_ADDR = NUM_DOM * DOM_STRIDE;

   if (NUM_DOM < 1 || NUM_DOM > 31) begin : g_bad_dom
      $error("NUM_DOM must lie in 1..31");
   end
   if (DOM_W != ((NUM_DOM > 1) ? $clog2(NUM_DOM) : 1)) begin : g_bad_domw
      $error("DOM_W must not be overridden");
   end
   if (SW_N < 1 || SW_N > 8) begin : g_bad_sw
      $error("SW_N must lie in 1..8");
   end
   if (GATE_W < SW_N + 1 || GATE_W > 32) begin : g_bad_gate
      $error("GATE_W must cover the switch word and fit 32 bits");
   end
   if (SETTLE_W < 1) begin : g_bad_settle
      $error("SETTLE_W must be at least 1");
   end
   if (STATUS_ADDR + 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register view");
   end

   // sequencer state
   logic                busy_q, up_q, done_q, err_q;
   logic [DOM_W-1:0]    dom_q;
   logic [STEP_W-1:0]   step_q;
   logic [SETTLE_W-1:0] len_q;

   logic                at_end, last, adv;
   reg_sel_t            sel;
   logic [GATE_W-1:0]   val;

   logic [GATE_W-1:0]   gate_v [NUM_DOM];
   logic [1:0]          ctrl_v [NUM_DOM];
   logic [SW_N:0]       sw_v   [NUM_DOM];
   logic [NUM_DOM-1:0]  on_v;
   logic [DOM_SLOTS-1:0] on_pad;

   always_comb begin
      on_pad = '0;
      on_pad[NUM_DOM-1:0] = on_v;
   end

   logic dom_ok, accept, noop, start;
   assign dom_ok = ({1'b0, req_dom} < (DOM_W + 1)'(NUM_DOM));
   assign accept = req_valid && !busy_q && dom_ok;
   assign noop   = accept && (on_pad[req_dom] == req_up);
   assign start  = accept && !noop;
   assign adv    = busy_q && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         up_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         dom_q  <= '0;
         step_q <= '0;
         len_q  <= '0;
      end else begin
         done_q <= noop || (adv && last);
         if (req_valid && (busy_q || !dom_ok)) err_q <= 1'b1;
         if (start) begin
            busy_q <= 1'b1;
            up_q   <= req_up;
            dom_q  <= req_dom;
            step_q <= '0;
            len_q  <= settle_len;
         end else if (adv) begin
            if (last) busy_q <= 1'b0;
            else      step_q <= step_q + 1'b1;
         end
      end
   end

   pgs_settle_timer #(.W(SETTLE_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start || adv),
      .run    (busy_q),
      .len    (len_q),
      .at_end (at_end)
   );

   pgs_step_table #(.SW_N(SW_N), .GATE_W(GATE_W), .STEP_W(STEP_W)) i_table (
      .up   (up_q),
      .idx  (step_q),
      .sel  (sel),
      .val  (val),
      .last (last)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic wr;
      assign wr = adv && (dom_q == DOM_W'(d));

      pgs_domain #(.SW_N(SW_N), .GATE_W(GATE_W)) i_dom (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr),
         .sel    (sel),
         .val    (val),
         .fin    (wr && last),
         .fin_up (up_q),
         .gate_q (gate_v[d]),
         .ctrl_q (ctrl_v[d]),
         .sw_q   (sw_v[d]),
         .on_q   (on_v[d])
      );

      assign dom_clk_en[d]            = ctrl_v[d][1];
      assign dom_rst[d]               = ctrl_v[d][0];
      assign dom_sw[d*SW_N +: SW_N]   = sw_v[d][SW_N-1:0];
      assign dom_iso[d]               = ~sw_v[d][SW_N];
   end

   // read view
   always_comb begin
      rd_data = '0;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (rd_addr == ADDR_W'(d * DOM_STRIDE))     rd_data = 32'(gate_v[d]);
         if (rd_addr == ADDR_W'(d * DOM_STRIDE + 4)) rd_data = 32'(ctrl_v[d]);
         if (rd_addr == ADDR_W'(d * DOM_STRIDE + 8)) rd_data = 32'(sw_v[d]);
      end
      if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
         rd_data[NUM_DOM-1:0] = on_v;
         rd_data[31]          = err_q;
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/pwr_gate_seq_chk.sv
`timescale 1ns/1ps
module pwr_gate_seq_chk #(
   parameter int NUM_DOM = 3,
   parameter int SW_N    = 4
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    busy,
   input logic                    done,
   input logic                    err,
   input logic [NUM_DOM-1:0]      dom_clk_en,
   input logic [NUM_DOM-1:0]      dom_rst,
   input logic [NUM_DOM*SW_N-1:0] dom_sw,
   input logic [NUM_DOM-1:0]      dom_iso
);
   logic [SW_N+2:0]    snap [NUM_DOM];
   logic [SW_N+2:0]    prev [NUM_DOM];
   logic               prev_v;
   logic [NUM_DOM-1:0] chg;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_d
      logic [SW_N-1:0] sw;
      assign sw      = dom_sw[d*SW_N +: SW_N];
      assign snap[d] = {dom_clk_en[d], dom_rst[d], sw, dom_iso[d]};
      assign chg[d]  = prev_v && (snap[d] != prev[d]);

      a_r10_sw_thermo: assert property (@(posedge clk) disable iff (!rst_n)
         ((sw & (sw + 1'b1)) == '0));
      a_r10_run_needs_sw: assert property (@(posedge clk) disable iff (!rst_n)
         !dom_rst[d] |-> (&sw));
      a_r10_iso_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
         !dom_iso[d] |-> (dom_clk_en[d] && !dom_rst[d]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v <= 1'b0;
         for (int d = 0; d < NUM_DOM; d++) prev[d] <= '0;
      end else begin
         prev_v <= 1'b1;
         for (int d = 0; d < NUM_DOM; d++) prev[d] <= snap[d];
      end
   end

   a_r11_one_domain: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1);
   a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r7_err_on_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> err);
endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(.NUM_DOM(NUM_DOM), .SW_N(SW_N)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .busy       (busy),
   .done       (done),
   .err        (err_q),
   .dom_clk_en (dom_clk_en),
   .dom_rst    (dom_rst),
   .dom_sw     (dom_sw),
   .dom_iso    (dom_iso)
);

// File: tb/test_pwr_gate_seq.sv
`timescale 1ns/1ps
module test_pwr_gate_seq;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_up = 1'b0;
   logic [1:0]  req_dom = '0;
   logic [7:0]  settle_len = '0;
   logic        busy, done;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [N-1:0]   dom_clk_en, dom_rst, dom_iso;
   logic [N*4-1:0] dom_sw;

   always #2 clk = ~clk;

   pwr_gate_seq i_pwr_gate_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_up(req_up),
      .req_dom(req_dom), .settle_len(settle_len), .busy(busy), .done(done),
      .rd_addr(rd_addr), .rd_data(rd_data), .dom_clk_en(dom_clk_en),
      .dom_rst(dom_rst), .dom_sw(dom_sw), .dom_iso(dom_iso)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit [31:0] e_gate [N];
   bit [31:0] e_ctrl [N];
   bit [31:0] e_sw   [N];
   bit        e_on   [N];
   bit        e_err;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog: act=still running exp=finished");
      summary();
   end

   task automatic check(input string r, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: act=%h exp=%h", r, what, act, exp);
      end
   endtask

   // stage values from R2 (up) and R3 (down); sel 0 gate, 1 control, 2 switch
   task automatic spec_step(input bit up, input int k, output int sel,
                            output bit [31:0] v);
      if (up) begin
         case (k)
            0: begin sel = 1; v = 3; end
            1: begin sel = 0; v = 32'h01FF_FFFE; end
            2, 3, 4, 5: begin sel = 2; v = (32'd1 << (k - 1)) - 1; end
            6: begin sel = 0; v = 32'h01FF_FFFF; end
            7: begin sel = 1; v = 2; end
            default: begin sel = 2; v = 32'h1F; end
         endcase
      end else begin
         case (k)
            0: begin sel = 2; v = 32'h0F; end
            1: begin sel = 0; v = 0; end
            2: begin sel = 1; v = 3; end
            3: begin sel = 1; v = 1; end
            default: begin sel = 2; v = 0; end
         endcase
      end
   endtask

   task automatic apply(input int d, input int sel, input bit [31:0] v);
      if (sel == 0)      e_gate[d] = v;
      else if (sel == 1) e_ctrl[d] = v;
      else               e_sw[d]   = v;
   endtask

   task automatic check_dom(input int d, input string r);
      rd_addr = 8'(d * 12);     #0.1;
      check(r, rd_data, e_gate[d], $sformatf("dom%0d gate word", d));
      rd_addr = 8'(d * 12 + 4); #0.1;
      check(r, rd_data, e_ctrl[d], $sformatf("dom%0d control word", d));
      rd_addr = 8'(d * 12 + 8); #0.1;
      check(r, rd_data, e_sw[d], $sformatf("dom%0d switch word", d));
      check(r, {dom_clk_en[d], dom_rst[d], dom_sw[d*4 +: 4], dom_iso[d]},
            {e_ctrl[d][1], e_ctrl[d][0], e_sw[d][3:0], ~e_sw[d][4]},
            $sformatf("dom%0d pins", d));
   endtask

   task automatic check_all(input string r);
      bit [31:0] st;
      for (int d = 0; d < N; d++) check_dom(d, r);
      st = '0;
      for (int d = 0; d < N; d++) st[d] = e_on[d];
      st[31] = e_err;
      rd_addr = 8'(N * 12);     #0.1;
      check(r, rd_data, st, "status word");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int d = 0; d < N; d++) begin
         e_gate[d] = 0; e_ctrl[d] = 1; e_sw[d] = 0; e_on[d] = 0;
      end
      e_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R4 timing: stage k lands (k+1)*(S+1) edges after acceptance
   task automatic run_seq(input int d, input bit up, input int s);
      int n;
      int total;
      int sel;
      bit [31:0] v;
      n = up ? 9 : 5;
      total = n * (s + 1);
      req_valid = 1; req_up = up; req_dom = 2'(d); settle_len = 8'(s);
      @(negedge clk);
      req_valid = 0;
      check("R5", 32'(busy), 1, "busy after accept");
      check_dom(d, "R4");
      for (int c = 1; c <= total; c++) begin
         @(negedge clk);
         if (c % (s + 1) == 0) begin
            spec_step(up, c / (s + 1) - 1, sel, v);
            apply(d, sel, v);
         end
         check("R5", 32'(busy), 32'(c < total), $sformatf("busy cycle %0d", c));
         check("R5", 32'(done), 32'(c == total), $sformatf("done cycle %0d", c));
         check_dom(d, up ? "R2/R4" : "R3/R4");
      end
      e_on[d] = up;
      check_all("R11");
   endtask

   task automatic noop_req(input int d, input bit up);
      req_valid = 1; req_up = up; req_dom = 2'(d); settle_len = 8'd2;
      @(negedge clk);
      req_valid = 0;
      check("R6", 32'(done), 1, "done after no-op");
      check("R6", 32'(busy), 0, "busy after no-op");
      check_all("R6");
      @(negedge clk);
      check("R6", 32'(done), 0, "done pulse width");
   endtask

   initial begin
      do_reset();
      check("R1", 32'(busy), 0, "busy at reset");
      check("R1", 32'(done), 0, "done at reset");
      check_all("R1");
      rd_addr = 8'hFF; #0.1;
      check("R9", rd_data, 0, "unmapped address");
      rd_addr = 8'(N * 12 + 4); #0.1;
      check("R9", rd_data, 0, "address above status");
      @(negedge clk);

      foreach (e_on[i]) ;
      for (int si = 0; si < 3; si++) begin
         int s;
         s = (si == 2) ? 3 : si;
         for (int d = 0; d < N; d++) run_seq(d, 1'b1, s);
         noop_req(si, 1'b1);
         for (int d = 0; d < N; d++) run_seq(d, 1'b0, s);
         noop_req(si, 1'b0);
      end

      // R8: index beyond the last domain
      req_valid = 1; req_up = 1; req_dom = 2'd3; settle_len = 0;
      @(negedge clk);
      req_valid = 0;
      check("R8", 32'(busy), 0, "busy after bad index");
      check("R8", 32'(done), 0, "done after bad index");
      e_err = 1;
      check_all("R8");

      // R7: request during a running sequence
      do_reset();
      req_valid = 1; req_up = 1; req_dom = 2'd0; settle_len = 8'd2;
      @(negedge clk);
      req_dom = 2'd1;
      @(negedge clk);
      req_valid = 0;
      e_err = 1;
      rd_addr = 8'(N * 12); #0.1;
      check("R7", rd_data, 32'h8000_0000, "status after busy request");
      for (int i = 0; i < 60 && busy; i++) @(negedge clk);
      e_gate[0] = 32'h01FF_FFFF; e_ctrl[0] = 2; e_sw[0] = 32'h1F; e_on[0] = 1;
      check_all("R7");
      repeat (40) @(negedge clk);
      check("R7", 32'(busy), 0, "no second sequence");
      check_all("R7");

      summary();
   end
endmodule